// File: doc/BRIEF.md
# Alternate-Space Access Decoder

This block takes load and store requests aimed at an alternate address space. Each request carries an 8-bit space identifier (ASI), an access size code, an address and store data. The block classifies the request by its space identifier and by its direction. It then sends it to one of three destinations: a supervisor code-memory read port, a physical-address passthrough port, or a block copy/fill engine. Cache-maintenance spaces are accepted and dropped without any port activity. Every other space raises an unassigned-access fault strobe toward the fault recorder, and a load that faults returns zero.

Requests enter through a valid/ready handshake. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so it applies back-pressure for the whole life of a request. The requester must keep `req_valid` and the request fields steady until the request is taken. Completion is signalled by a single-cycle `rsp_done`, and `rsp_rdata` is valid in that cycle. The three downstream ports use request/acknowledge: a request stays high with steady fields until its acknowledge is seen.

Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.

Top module: `asi_access_decoder`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `rsp_done`, `flt_strobe`, `code_req`, `phys_req` and `blk_req` are all 0.
- R2: A request is taken when `req_valid` and `req_ready` are both high. After that, `req_ready` stays low until `rsp_done` has been high for exactly one cycle, and then returns high. An ignored or faulting request completes in the cycle right after it is taken.
- R3: Loads and stores to space 0x02 or to spaces 0x0C through 0x0F make no port request and raise no fault. A load of this kind returns 0.
- R4: A load from space 0x09 reads code memory. `code_addr` is the request address with bit 0 cleared for size 1, with bits 1:0 cleared for size 2, and unchanged for size 0. `code_size` equals the request size. The returned word comes back in `rsp_rdata[31:0]`, and the upper half is 0.
- R5: A size-3 load from space 0x09 makes two size-2 code reads, the first at the address with bits 1:0 cleared and the second 4 above it. `rsp_rdata` holds the first word in bits 63:32 and the second in bits 31:0.
- R6: Space 0x20 is a physical passthrough for loads and stores. The port gets the request address, size, direction and store data unchanged, and a load returns `phys_rdata`.
- R7: Stores to spaces 0x10 to 0x14, 0x31, 0x36 and 0x37 make no port request and raise no fault.
- R8: Stores to space 0x17 (copy, `blk_fill`=0) and 0x1F (fill, `blk_fill`=1) go to the block engine with the request address and store data.
- R9: Every other pairing of space and direction raises `flt_strobe` in the same cycle as `rsp_done`. This includes loads from 0x10 to 0x1F, any access to 0x21 to 0x2F, and stores to 0x09. The strobe carries `flt_write` equal to the request direction, plus the request address and space. A faulting load returns 0.
- R10: Each downstream request holds steady, with an unchanged address, until its acknowledge arrives. At most one downstream request is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_asi | input | 8 | Space identifier |
| req_size | input | 2 | Size code |
| req_addr | input | AW | Request address |
| req_wdata | input | 64 | Store data |
| rsp_done | output | 1 | One-cycle completion |
| rsp_rdata | output | 64 | Load data, valid with rsp_done |
| code_req | output | 1 | Code-memory read request |
| code_addr | output | AW | Aligned code address |
| code_size | output | 2 | Code read size code |
| code_ack | input | 1 | Code read acknowledge |
| code_rdata | input | 32 | Code read data, right-justified |
| phys_req | output | 1 | Passthrough request |
| phys_write | output | 1 | Passthrough direction |
| phys_size | output | 2 | Passthrough size code |
| phys_addr | output | AW | Passthrough address |
| phys_wdata | output | 64 | Passthrough store data |
| phys_ack | input | 1 | Passthrough acknowledge |
| phys_rdata | input | 64 | Passthrough load data |
| blk_req | output | 1 | Block engine request |
| blk_fill | output | 1 | 1 = fill, 0 = copy |
| blk_addr | output | AW | Block destination address |
| blk_wdata | output | 64 | Block source address or fill pattern |
| blk_ack | input | 1 | Block engine acknowledge |
| flt_strobe | output | 1 | Unassigned-access fault pulse |
| flt_write | output | 1 | Faulting access was a store |
| flt_asi | output | 8 | Faulting space |
| flt_addr | output | AW | Faulting address |

## Verification
The hardest case to reach from the ports is an 8-byte code load whose two reads each see a late acknowledge. It needs the second address to appear only after the first word is captured, and both words must land in the right halves. The stimulus sweeps all 256 space values in both directions, with the responder latency varied per request from zero to two cycles. A dedicated pass then runs the code space through every size code against all eight low-order address patterns, so alignment and the two-word order are covered under held requests.

// File: rtl/asi_dec_pkg.sv
package asi_dec_pkg;
  localparam int ASI_W = 8;
  localparam int DW    = 64;
  localparam int WW    = 32;

  typedef enum logic [2:0] {RT_IGNORE, RT_CODE, RT_PHYS, RT_BLOCK, RT_FAULT} route_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} state_e;
  typedef enum logic [1:0] {CS_IDLE, CS_FIRST, CS_SECOND} code_st_e;
endpackage

// File: rtl/asi_route_decode.sv
module asi_route_decode
  import asi_dec_pkg::*;
(
  input  logic [ASI_W-1:0] asi,
  input  logic             write,
  output route_e           route,
  output logic             blk_fill
);
  always_comb begin
    route    = RT_FAULT;
    blk_fill = 1'b0;
    case (asi)
      8'h02, 8'h0C, 8'h0D, 8'h0E, 8'h0F: route = RT_IGNORE;
      8'h09: route = write ? RT_FAULT : RT_CODE;
      8'h20: route = RT_PHYS;
      8'h10, 8'h11, 8'h12, 8'h13, 8'h14,
      8'h31, 8'h36, 8'h37: route = write ? RT_IGNORE : RT_FAULT;
      8'h17: route = write ? RT_BLOCK : RT_FAULT;
      8'h1F: begin
        route    = write ? RT_BLOCK : RT_FAULT;
        blk_fill = 1'b1;
      end
      default: route = RT_FAULT;
    endcase
  end
endmodule

// File: rtl/asi_port_hold.sv
module asi_port_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic req,
  output logic done
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_q <= 1'b0;
    else if (start)      busy_q <= 1'b1;
    else if (busy_q && ack) busy_q <= 1'b0;
  end

  assign req  = busy_q;
  assign done = busy_q && ack;
endmodule

// File: rtl/asi_code_seq.sv
module asi_code_seq
  import asi_dec_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          code_req,
  output logic [AW-1:0] code_addr,
  output logic [1:0]    code_size,
  input  logic          code_ack,
  input  logic [WW-1:0] code_rdata,
  output logic          done,
  output logic [DW-1:0] data
);
  code_st_e      st_q;
  logic [AW-1:0] base_q;
  logic [1:0]    size_q;
  logic [WW-1:0] hi_q;
  logic [AW-1:0] mask;
  logic          pair;

  always_comb begin
    mask = '1;
    if (size == 2'd1) mask[0] = 1'b0;
    if (size[1])      mask[1:0] = 2'b00;
  end

  assign pair = (size_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      base_q <= '0;
      size_q <= '0;
      hi_q   <= '0;
    end else begin
      case (st_q)
        CS_IDLE: if (start) begin
          base_q <= addr & mask;
          size_q <= size;
          st_q   <= CS_FIRST;
        end
        CS_FIRST: if (code_ack) begin
          hi_q <= code_rdata;
          st_q <= pair ? CS_SECOND : CS_IDLE;
        end
        CS_SECOND: if (code_ack) st_q <= CS_IDLE;
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign code_req  = (st_q == CS_FIRST) || (st_q == CS_SECOND);
  assign code_addr = (st_q == CS_SECOND) ? base_q + AW'(4) : base_q;
  assign code_size = pair ? 2'd2 : size_q;
  assign done      = code_ack && (((st_q == CS_FIRST) && !pair) || (st_q == CS_SECOND));
  assign data      = pair ? {hi_q, code_rdata} : {{WW{1'b0}}, code_rdata};
endmodule

// File: rtl/asi_access_decoder.sv
module asi_access_decoder
  import asi_dec_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [ASI_W-1:0] req_asi,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  output logic             code_req,
  output logic [AW-1:0]    code_addr,
  output logic [1:0]       code_size,
  input  logic             code_ack,
  input  logic [WW-1:0]    code_rdata,
  output logic             phys_req,
  output logic             phys_write,
  output logic [1:0]       phys_size,
  output logic [AW-1:0]    phys_addr,
  output logic [DW-1:0]    phys_wdata,
  input  logic             phys_ack,
  input  logic [DW-1:0]    phys_rdata,
  output logic             blk_req,
  output logic             blk_fill,
  output logic [AW-1:0]    blk_addr,
  output logic [DW-1:0]    blk_wdata,
  input  logic             blk_ack,
  output logic             flt_strobe,
  output logic             flt_write,
  output logic [ASI_W-1:0] flt_asi,
  output logic [AW-1:0]    flt_addr
);
  state_e           state_q;
  route_e           dec_route, route_q;
  logic             dec_fill, fill_q, wr_q;
  logic [ASI_W-1:0] asi_q;
  logic [1:0]       size_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rdata_q, code_data;
  logic             accept, code_done, phys_done, blk_done;

  asi_route_decode u_dec (
    .asi(req_asi), .write(req_write), .route(dec_route), .blk_fill(dec_fill)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  asi_code_seq #(.AW(AW)) u_code (
    .clk(clk), .rst_n(rst_n),
    .start(accept && dec_route == RT_CODE),
    .addr(req_addr), .size(req_size),
    .code_req(code_req), .code_addr(code_addr), .code_size(code_size),
    .code_ack(code_ack), .code_rdata(code_rdata),
    .done(code_done), .data(code_data)
  );

  asi_port_hold u_phys (
    .clk(clk), .rst_n(rst_n), .start(accept && dec_route == RT_PHYS),
    .ack(phys_ack), .req(phys_req), .done(phys_done)
  );

  asi_port_hold u_blk (
    .clk(clk), .rst_n(rst_n), .start(accept && dec_route == RT_BLOCK),
    .ack(blk_ack), .req(blk_req), .done(blk_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      route_q <= RT_IGNORE;
      fill_q  <= 1'b0;
      wr_q    <= 1'b0;
      asi_q   <= '0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          route_q <= dec_route;
          fill_q  <= dec_fill;
          wr_q    <= req_write;
          asi_q   <= req_asi;
          size_q  <= req_size;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          rdata_q <= '0;
          state_q <= (dec_route inside {RT_CODE, RT_PHYS, RT_BLOCK}) ? ST_WAIT : ST_RESP;
        end
        ST_WAIT: begin
          if (code_done) begin
            rdata_q <= code_data;
            state_q <= ST_RESP;
          end else if (phys_done) begin
            if (!wr_q) rdata_q <= phys_rdata;
            state_q <= ST_RESP;
          end else if (blk_done) begin
            state_q <= ST_RESP;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_done   = (state_q == ST_RESP);
  assign rsp_rdata  = rdata_q;
  assign phys_write = wr_q;
  assign phys_size  = size_q;
  assign phys_addr  = addr_q;
  assign phys_wdata = wdata_q;
  assign blk_fill   = fill_q;
  assign blk_addr   = addr_q;
  assign blk_wdata  = wdata_q;
  assign flt_strobe = rsp_done && (route_q == RT_FAULT);
  assign flt_write  = wr_q;
  assign flt_asi    = asi_q;
  assign flt_addr   = addr_q;
endmodule

// File: rtl/asi_access_decoder_chk.sv
module asi_access_decoder_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          flt_strobe,
  input logic          code_req,
  input logic          code_ack,
  input logic [AW-1:0] code_addr,
  input logic [1:0]    code_size,
  input logic          phys_req,
  input logic          phys_ack,
  input logic [AW-1:0] phys_addr,
  input logic          blk_req
);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r9_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    flt_strobe |-> rsp_done);
  a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (code_req && !code_ack) |=> (code_req && $stable(code_addr)));
  a_r10_phys_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_req && !phys_ack) |=> (phys_req && $stable(phys_addr)));
  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({code_req, phys_req, blk_req}));
  a_r4_half_align: assert property (@(posedge clk) disable iff (!rst_n)
    (code_req && code_size == 2'd1) |-> !code_addr[0]);
  a_r4_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    (code_req && code_size == 2'd2) |-> (code_addr[1:0] == 2'b00));
endmodule

bind asi_access_decoder asi_access_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .flt_strobe(flt_strobe),
  .code_req(code_req), .code_ack(code_ack), .code_addr(code_addr), .code_size(code_size),
  .phys_req(phys_req), .phys_ack(phys_ack), .phys_addr(phys_addr), .blk_req(blk_req)
);

// File: tb/asi_access_decoder_test.sv
module asi_access_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [7:0]  req_asi = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_done;
  logic [63:0] rsp_rdata;
  logic        code_req, code_ack = 1'b0;
  logic [31:0] code_addr, code_rdata = '0;
  logic [1:0]  code_size;
  logic        phys_req, phys_write, phys_ack = 1'b0;
  logic [1:0]  phys_size;
  logic [31:0] phys_addr;
  logic [63:0] phys_wdata, phys_rdata = '0;
  logic        blk_req, blk_fill, blk_ack = 1'b0;
  logic [31:0] blk_addr;
  logic [63:0] blk_wdata;
  logic        flt_strobe, flt_write;
  logic [7:0]  flt_asi;
  logic [31:0] flt_addr;

  asi_access_decoder #(.AW(32)) uut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int lat_g = 0;
  int ccnt = 0, pcnt = 0;

  int          n_code, n_phys, n_blk;
  logic [31:0] c_addr[2];
  logic [1:0]  c_size[2];
  logic [31:0] p_addr, b_addr;
  logic [63:0] p_wdata, b_wdata;
  logic [1:0]  p_size;
  logic        p_write, b_fill;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // responders drive acks away from the active edge
  always @(negedge clk) begin
    if (code_ack) code_ack = 1'b0;
    else if (code_req) begin
      if (ccnt >= lat_g) begin code_ack = 1'b1; code_rdata = ~code_addr; ccnt = 0; end
      else ccnt++;
    end
    if (phys_ack) phys_ack = 1'b0;
    else if (phys_req) begin
      if (pcnt >= lat_g) begin phys_ack = 1'b1; phys_rdata = {phys_addr, ~phys_addr}; pcnt = 0; end
      else pcnt++;
    end
    if (blk_ack) blk_ack = 1'b0;
    else if (blk_req) blk_ack = 1'b1;
  end

  always @(posedge clk) begin
    if (code_req && code_ack && n_code < 2) begin
      c_addr[n_code] = code_addr; c_size[n_code] = code_size; n_code++;
    end
    if (phys_req && phys_ack) begin
      n_phys++; p_addr = phys_addr; p_size = phys_size; p_write = phys_write; p_wdata = phys_wdata;
    end
    if (blk_req && blk_ack) begin
      n_blk++; b_addr = blk_addr; b_fill = blk_fill; b_wdata = blk_wdata;
    end
  end

  task automatic run(input bit wr, input logic [7:0] asi, input logic [1:0] sz,
                     input logic [31:0] addr, input logic [63:0] wd, input int lat);
    int waited;
    bit ign, code, phys, blk, flt;
    logic [31:0] base;
    logic [63:0] exp_rd;
    lat_g = lat; n_code = 0; n_phys = 0; n_blk = 0;
    ign  = (asi == 8'h02) || (asi >= 8'h0C && asi <= 8'h0F) ||
           (wr && ((asi >= 8'h10 && asi <= 8'h14) || asi == 8'h31 || asi == 8'h36 || asi == 8'h37));
    code = !wr && asi == 8'h09;
    phys = asi == 8'h20;
    blk  = wr && (asi == 8'h17 || asi == 8'h1F);
    flt  = !(ign || code || phys || blk);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_asi = asi; req_size = sz; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waited = 1;
    while (!rsp_done && waited < 60) begin @(negedge clk); waited++; end
    chk(rsp_done == 1'b1, "R2 completion", 64'(rsp_done), 64'd1);
    if (ign || flt) chk(waited == 1, "R2 one-cycle completion", 64'(waited), 64'd1);
    chk(req_ready == 1'b0, "R2 ready low while busy", 64'(req_ready), 64'd0);
    // port activity
    if (sz == 2'd0)      base = addr;
    else if (sz == 2'd1) base = addr & ~32'd1;
    else                 base = addr & ~32'd3;
    if (code && sz == 2'd3) begin
      chk(n_code == 2, "R5 two code reads", 64'(n_code), 64'd2);
      chk(c_addr[0] == base && c_addr[1] == base + 32'd4 && c_size[0] == 2'd2 && c_size[1] == 2'd2,
          "R5 code addresses", {c_addr[0], c_addr[1]}, {base, base + 32'd4});
      exp_rd = {~base, ~(base + 32'd4)};
    end else if (code) begin
      chk(n_code == 1, "R4 one code read", 64'(n_code), 64'd1);
      chk(c_addr[0] == base && c_size[0] == sz, "R4 code address", {30'd0, c_size[0], c_addr[0]},
          {30'd0, sz, base});
      exp_rd = {32'd0, ~base};
    end else begin
      chk(n_code == 0, "R9 no code read", 64'(n_code), 64'd0);
      exp_rd = 64'd0;
    end
    if (phys) begin
      chk(n_phys == 1 && p_addr == addr && p_size == sz && p_write == wr && p_wdata == wd,
          "R6 R10 passthrough fields", {p_addr, 29'd0, p_write, p_size}, {addr, 29'd0, wr, sz});
      if (!wr) exp_rd = {addr, ~addr};
    end else chk(n_phys == 0, "R3 no passthrough", 64'(n_phys), 64'd0);
    if (blk) chk(n_blk == 1 && b_addr == addr && b_wdata == wd && b_fill == (asi == 8'h1F),
                 "R8 block engine fields", {b_addr, 31'd0, b_fill}, {addr, 31'd0, asi == 8'h1F});
    else chk(n_blk == 0, "R7 no block request", 64'(n_blk), 64'd0);
    chk(flt_strobe == flt, "R9 fault strobe", 64'(flt_strobe), 64'(flt));
    if (flt) chk(flt_write == wr && flt_asi == asi && flt_addr == addr, "R9 fault fields",
                 {23'd0, flt_write, flt_asi, flt_addr}, {23'd0, wr, asi, addr});
    if (!wr) chk(rsp_rdata == exp_rd, "R3 R4 R5 R6 R9 load data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(rsp_done == 1'b0 && req_ready == 1'b1, "R2 done single cycle",
        {62'd0, rsp_done, req_ready}, 64'd1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_done && !flt_strobe && !code_req && !phys_req && !blk_req, "R1 reset state",
        {58'd0, req_ready, rsp_done, flt_strobe, code_req, phys_req, blk_req}, 64'h20);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_done && !flt_strobe, "R1 after reset",
        {61'd0, req_ready, rsp_done, flt_strobe}, 64'h4);
    for (int a = 0; a < 256; a++) begin
      for (int w = 0; w < 2; w++) begin
        logic [31:0] ad;
        ad = 32'h4000_0003 + 32'(a) * 32'h0101_0105;
        run(w[0], 8'(a), 2'(a % 4), ad, {~ad, ad ^ 32'h5A5A_A5A5}, (a + w) % 3);
      end
    end
    for (int s = 0; s < 4; s++) begin
      for (int lo = 0; lo < 8; lo++) begin
        run(1'b0, 8'h09, 2'(s), 32'h8765_4320 | 32'(lo), 64'd0, (s + lo) % 3);
      end
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end
endmodule